// File: doc/BRIEF.md
# Dual-Sided Doorbell Register

This block holds a 32-bit doorbell word that two parties share within one clock domain. A remote requester can only raise bits: every position it writes as 1 becomes set, and positions it writes as 0 keep their value. The local processor can only lower bits: every position it writes as 1 is cleared, and positions it writes as 0 keep their value. A local software handler reads the word, services the doorbells it finds, and clears them by writing the same pattern back.

The low 31 bits are ordinary doorbells. They are ANDed with a 31-bit enable mask that the local side owns, and the result is ORed into a level interrupt. Bit 31 is reserved for urgent faults. It drives a separate machine-check request that the mask does not affect. Each output is produced by a two-state level machine with the states QUIET and RAISED. QUIET moves to RAISED when the condition behind it becomes true, and RAISED moves back to QUIET when the condition becomes false. This adds one registered cycle between the doorbell word and each output pin.

The local port has one select bit for writes and one for reads. A select of 0 addresses the doorbell word and a select of 1 addresses the mask. The remote port always addresses the doorbell word.

Top module: `dual_doorbell`

## Requirements
- R1: After reset the doorbell word, the mask, `db_irq` and `mchk_req` are all zero.
- R2: A remote write (`rmt_wr_en`=1) sets every doorbell bit whose data bit is 1 at the clock edge and leaves the other bits unchanged. The new value is readable on both read ports after that edge.
- R3: A local write with `loc_wr_sel`=0 clears every doorbell bit whose data bit is 1 and leaves the other bits unchanged. When neither side writes the doorbell word, it holds its value.
- R4: When the same bit is set remotely and cleared locally in the same cycle, the bit ends up set. Other bits in the local write are still cleared.
- R5: A local write with `loc_wr_sel`=1 loads `loc_wr_data[30:0]` into the mask and leaves the doorbell word unchanged. A local read with `loc_rd_sel`=1 returns `{1'b0, mask}`.
- R6: `db_irq` is a level output. It is 1 exactly one cycle after a cycle in which some bit of doorbell[30:0] and the same mask bit are both 1. It stays high for as long as that condition holds, and it drops one cycle after the condition ends.
- R7: `mchk_req` equals doorbell bit 31 delayed by one cycle. It is not affected by the mask, and bit 31 never raises `db_irq`.
- R8: A doorbell bit whose mask bit is 0 does not raise `db_irq`, but it is still set and still readable.
- R9: `rmt_rd_data` always returns the doorbell word. `loc_rd_data` returns the doorbell word when `loc_rd_sel`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmt_wr_en | input | 1 | Remote write strobe |
| rmt_wr_data | input | 32 | Remote set pattern |
| rmt_rd_data | output | 32 | Doorbell word as seen by the remote side |
| loc_wr_en | input | 1 | Local write strobe |
| loc_wr_sel | input | 1 | Local write target: 0 clears doorbell bits, 1 loads the mask |
| loc_wr_data | input | 32 | Local clear pattern or mask value |
| loc_rd_sel | input | 1 | Local read target: 0 selects the doorbell word, 1 selects the mask |
| loc_rd_data | output | 32 | Local read data |
| db_irq | output | 1 | Masked doorbell interrupt (level) |
| mchk_req | output | 1 | Machine-check request that follows bit 31 |

## Verification
The bench drives a set and a clear of the same bit in one cycle. A design that let the clear win would lose that doorbell and read back 0 in its place. It loads the mask while doorbells are already pending and checks that the doorbell word is unchanged. It also checks that `db_irq` rises exactly one cycle later, which exposes a mask write that corrupts the word or an output that is a cycle early or late. It sets bit 31 while every mask bit is enabled. A design that folded bit 31 into the interrupt, or gated the machine check with the mask, would show the wrong level on one of the two outputs. Writes with all-zero patterns check that untouched bits keep their value.

// File: rtl/dual_doorbell_pkg.sv
package dual_doorbell_pkg;

    // Local port target select values
    localparam logic LOC_SEL_DOORBELL = 1'b0;
    localparam logic LOC_SEL_MASK     = 1'b1;

    // Two-state level machine used for both outputs
    typedef enum logic {
        LVL_QUIET  = 1'b0,
        LVL_RAISED = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/dual_doorbell_bitslice.sv
module dual_doorbell_bitslice (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic bit_o
);

    // A set has priority over a clear, so a doorbell is never lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_o <= 1'b0;
        end else if (set_i) begin
            bit_o <= 1'b1;
        end else if (clr_i) begin
            bit_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_doorbell_mask_reg.sv
module dual_doorbell_mask_reg #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (load_i) begin
            mask_o <= data_i;
        end
    end

endmodule

// File: rtl/dual_doorbell_level_fsm.sv
module dual_doorbell_level_fsm
    import dual_doorbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic active_o
);

    lvl_state_e state_q;
    lvl_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: QUIET -> RAISED on req, RAISED -> QUIET when req drops
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_QUIET:  if (req_i)  state_d = LVL_RAISED;
            LVL_RAISED: if (!req_i) state_d = LVL_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        active_o = (state_q == LVL_RAISED);
    end

endmodule

// File: rtl/dual_doorbell_irq_gen.sv
module dual_doorbell_irq_gen #(
    parameter int DATA_W = 32,
    localparam int DB_W  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] db_i,
    input  logic [DB_W-1:0]   mask_i,
    output logic              irq_o,
    output logic              mchk_o
);

    logic pend_irq;
    logic pend_mchk;

    always_comb begin
        pend_irq  = |(db_i[DB_W-1:0] & mask_i);
        pend_mchk = db_i[DATA_W-1];
    end

    dual_doorbell_level_fsm irq_fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (pend_irq),
        .active_o (irq_o)
    );

    dual_doorbell_level_fsm mchk_fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (pend_mchk),
        .active_o (mchk_o)
    );

endmodule

// File: rtl/dual_doorbell.sv
module dual_doorbell
    import dual_doorbell_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rmt_wr_en,
    input  logic [DATA_W-1:0] rmt_wr_data,
    output logic [DATA_W-1:0] rmt_rd_data,
    input  logic              loc_wr_en,
    input  logic              loc_wr_sel,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              loc_rd_sel,
    output logic [DATA_W-1:0] loc_rd_data,
    output logic              db_irq,
    output logic              mchk_req
);

    localparam int DB_W = DATA_W - 1;

    logic              clr_en;
    logic              mask_ld;
    logic [DATA_W-1:0] db_q;
    logic [DB_W-1:0]   mask_q;

    always_comb begin
        clr_en  = loc_wr_en && (loc_wr_sel == LOC_SEL_DOORBELL);
        mask_ld = loc_wr_en && (loc_wr_sel == LOC_SEL_MASK);
    end

    // One storage cell per doorbell bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        dual_doorbell_bitslice cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (rmt_wr_en & rmt_wr_data[i]),
            .clr_i (clr_en & loc_wr_data[i]),
            .bit_o (db_q[i])
        );
    end

    dual_doorbell_mask_reg #(.W(DB_W)) mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mask_ld),
        .data_i (loc_wr_data[DB_W-1:0]),
        .mask_o (mask_q)
    );

    dual_doorbell_irq_gen #(.DATA_W(DATA_W)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .db_i   (db_q),
        .mask_i (mask_q),
        .irq_o  (db_irq),
        .mchk_o (mchk_req)
    );

    // Read paths
    always_comb begin
        rmt_rd_data = db_q;
        if (loc_rd_sel == LOC_SEL_MASK) begin
            loc_rd_data = {1'b0, mask_q};
        end else begin
            loc_rd_data = db_q;
        end
    end

endmodule

// File: rtl/dual_doorbell_chk.sv
module dual_doorbell_chk #(
    parameter int DATA_W = 32,
    localparam int DB_W  = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rmt_wr_en,
    input logic [DATA_W-1:0] rmt_wr_data,
    input logic [DATA_W-1:0] rmt_rd_data,
    input logic              loc_wr_en,
    input logic              loc_wr_sel,
    input logic [DATA_W-1:0] loc_wr_data,
    input logic              loc_rd_sel,
    input logic [DATA_W-1:0] loc_rd_data,
    input logic              db_irq,
    input logic              mchk_req,
    input logic [DB_W-1:0]   mask
);

    // R2 and R4: every remotely written 1 is set after the edge
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_wr_en |=> ((rmt_rd_data & $past(rmt_wr_data)) == $past(rmt_wr_data)));

    // R3: locally cleared bits are 0 unless set in the same cycle
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr_en && !loc_wr_sel) |=>
        ((rmt_rd_data & $past(loc_wr_data) &
          ~($past(rmt_wr_en) ? $past(rmt_wr_data) : '0)) == '0));

    // R3: the word holds when nobody writes it
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rmt_wr_en && !(loc_wr_en && !loc_wr_sel)) |=> $stable(rmt_rd_data));

    // R5: mask load takes the low bits of the local data
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr_en && loc_wr_sel) |=> (mask == $past(loc_wr_data[DB_W-1:0])));

    // R5: the top bit of a mask read is 0
    p_mask_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd_sel |-> (loc_rd_data[DATA_W-1] == 1'b0));

    // R6 and R8: the interrupt follows the masked pending state one cycle later
    p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (db_irq == $past(|(rmt_rd_data[DB_W-1:0] & mask))));

    // R7: machine check follows bit 31 one cycle later
    p_mchk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mchk_req == $past(rmt_rd_data[DATA_W-1])));

    // R9: both read ports agree when the local side reads the doorbell word
    p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_rd_sel |-> (loc_rd_data == rmt_rd_data));

endmodule

bind dual_doorbell dual_doorbell_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rmt_wr_en   (rmt_wr_en),
    .rmt_wr_data (rmt_wr_data),
    .rmt_rd_data (rmt_rd_data),
    .loc_wr_en   (loc_wr_en),
    .loc_wr_sel  (loc_wr_sel),
    .loc_wr_data (loc_wr_data),
    .loc_rd_sel  (loc_rd_sel),
    .loc_rd_data (loc_rd_data),
    .db_irq      (db_irq),
    .mchk_req    (mchk_req),
    .mask        (mask_q)
);

// File: tb/dual_doorbell_tb_top.sv
module dual_doorbell_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rmt_wr_en = 1'b0;
    logic [31:0] rmt_wr_data = '0;
    logic [31:0] rmt_rd_data;
    logic        loc_wr_en = 1'b0;
    logic        loc_wr_sel = 1'b0;
    logic [31:0] loc_wr_data = '0;
    logic        loc_rd_sel = 1'b0;
    logic [31:0] loc_rd_data;
    logic        db_irq;
    logic        mchk_req;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    dual_doorbell dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rmt_wr_en   (rmt_wr_en),
        .rmt_wr_data (rmt_wr_data),
        .rmt_rd_data (rmt_rd_data),
        .loc_wr_en   (loc_wr_en),
        .loc_wr_sel  (loc_wr_sel),
        .loc_wr_data (loc_wr_data),
        .loc_rd_sel  (loc_rd_sel),
        .loc_rd_data (loc_rd_data),
        .db_irq      (db_irq),
        .mchk_req    (mchk_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each write lasts one cycle. The task returns at the negedge after the capturing edge.
    task automatic remote_write(input logic [31:0] d);
        @(negedge clk);
        rmt_wr_en = 1'b1; rmt_wr_data = d;
        @(negedge clk);
        rmt_wr_en = 1'b0; rmt_wr_data = '0;
    endtask

    task automatic local_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        loc_wr_en = 1'b1; loc_wr_sel = sel; loc_wr_data = d;
        @(negedge clk);
        loc_wr_en = 1'b0; loc_wr_sel = 1'b0; loc_wr_data = '0;
    endtask

    task automatic read_mask(output logic [31:0] v);
        loc_rd_sel = 1'b1;
        #1 v = loc_rd_data;
        loc_rd_sel = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] m;
        check("R1 doorbell", rmt_rd_data, 32'h0);
        read_mask(m);
        check("R1 mask", m, 32'h0);
        check("R1 irq", {31'b0, db_irq}, 32'h0);
        check("R1 mchk", {31'b0, mchk_req}, 32'h0);
    endtask

    task automatic t_set;
        remote_write(32'h0000_00F0);
        check("R2 set remote read", rmt_rd_data, 32'h0000_00F0);
        check("R9 local read", loc_rd_data, 32'h0000_00F0);
        remote_write(32'h0000_0103);
        check("R2 zeros keep bits", rmt_rd_data, 32'h0000_01F3);
    endtask

    task automatic t_clear;
        local_write(1'b0, 32'h0000_0030);
        check("R3 clear ones", loc_rd_data, 32'h0000_01C3);
        local_write(1'b0, 32'h0);
        check("R3 zero clear holds", rmt_rd_data, 32'h0000_01C3);
    endtask

    task automatic t_collide;
        @(negedge clk);
        rmt_wr_en = 1'b1; rmt_wr_data = 32'h0000_0C00;
        loc_wr_en = 1'b1; loc_wr_sel = 1'b0; loc_wr_data = 32'h0000_0C03;
        @(negedge clk);
        rmt_wr_en = 1'b0; rmt_wr_data = '0;
        loc_wr_en = 1'b0; loc_wr_data = '0;
        check("R4 set wins over clear", rmt_rd_data, 32'h0000_0DC0);
    endtask

    task automatic t_mask;
        logic [31:0] m;
        @(negedge clk);
        check("R8 masked bits raise no irq", {31'b0, db_irq}, 32'h0);
        check("R8 masked bits still readable", rmt_rd_data, 32'h0000_0DC0);
        local_write(1'b1, 32'h0000_0040);
        read_mask(m);
        check("R5 mask readback", m, 32'h0000_0040);
        check("R5 doorbell untouched", rmt_rd_data, 32'h0000_0DC0);
        check("R6 irq not yet", {31'b0, db_irq}, 32'h0);
        @(negedge clk);
        check("R6 irq one cycle later", {31'b0, db_irq}, 32'h1);
    endtask

    task automatic t_irq_level;
        logic [31:0] m;
        repeat (3) @(negedge clk);
        check("R6 irq level holds", {31'b0, db_irq}, 32'h1);
        local_write(1'b0, 32'h0000_0040);
        check("R6 irq lags clear", {31'b0, db_irq}, 32'h1);
        @(negedge clk);
        check("R6 irq drops", {31'b0, db_irq}, 32'h0);
        local_write(1'b1, 32'hFFFF_FFFF);
        read_mask(m);
        check("R5 mask top bit zero", m, 32'h7FFF_FFFF);
        @(negedge clk);
        check("R6 irq from unmasked bits", {31'b0, db_irq}, 32'h1);
        local_write(1'b0, 32'h7FFF_FFFF);
        check("R3 all cleared", rmt_rd_data, 32'h0);
        @(negedge clk);
        check("R6 irq off after clear", {31'b0, db_irq}, 32'h0);
    endtask

    task automatic t_mchk;
        remote_write(32'h8000_0000);
        check("R2 bit31 set", rmt_rd_data, 32'h8000_0000);
        check("R7 mchk lag", {31'b0, mchk_req}, 32'h0);
        @(negedge clk);
        check("R7 mchk raised with full mask", {31'b0, mchk_req}, 32'h1);
        check("R7 bit31 no irq", {31'b0, db_irq}, 32'h0);
        local_write(1'b1, 32'h0);
        @(negedge clk);
        check("R7 mchk ignores mask", {31'b0, mchk_req}, 32'h1);
        local_write(1'b0, 32'h8000_0000);
        check("R3 bit31 cleared", rmt_rd_data, 32'h0);
        @(negedge clk);
        check("R7 mchk drops", {31'b0, mchk_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_clear();
        t_collide();
        t_mask();
        t_irq_level();
        t_mchk();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule